// File: doc/BRIEF.md
# Keyboard Receive Holding Register with Interrupt

This block sits between a keyboard's serial interface and a host bus. A byte that the device presents while the holding register is empty is captured and the register becomes full. A full register raises an interrupt request to the host. The host collects the byte by reading a fixed data address, and that read empties the register.

The register holds one byte. While it is full the block never overwrites it and never flags an overrun. It pushes back on the device with a retry indication, and the device must keep offering the same byte until the retry drops. Because no new byte is captured, no new interrupt is raised. The interrupt is provided in two forms. One is a level that follows the full state. The other is a one-cycle pulse on each new fill. A status pin also exposes the full state, so a host can poll instead of taking interrupts.

Top module: `kbd_rx_hold`

## Requirements
- R1: After reset the register is empty: `full_o`, `irq_level_o`, `irq_pulse_o` and `dev_retry_o` are all 0.
- R2: When `dev_valid_i` is 1 at a rising edge while the register is empty, the byte on `dev_data_i` is captured, and `full_o` is 1 from that edge on.
- R3: `irq_level_o` is 1 exactly while the register is full. It returns to 0 after the edge on which a data read empties the register.
- R4: Each fill produces `irq_pulse_o` = 1 for exactly one cycle, in the cycle right after the capturing edge.
- R5: A read is `host_rd_i` = 1 with `host_addr_i` equal to DATA_ADDR (default 0x60). During a read, `host_rdata_o` shows the held byte combinationally. If the register is full, the read empties it at the next edge.
- R6: A read strobe at any other address returns `host_rdata_o` = 0 and leaves the register and its contents unchanged.
- R7: While the register is full, `dev_retry_o` equals `dev_valid_i` in the same cycle. The offered byte is not captured, the held byte is unchanged, and `irq_pulse_o` stays 0.
- R8: If a data read and a device byte arrive in the same cycle on a full register, the read returns the old byte and the device is told to retry. If the device still offers its byte in the next cycle, that byte is captured then and a new pulse follows.
- R9: `full_o` shows the full state for polling and is 0 again after the emptying read.
- R10: A data read while the register is empty leaves it empty and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_valid_i | input | 1 | Device offers a byte |
| dev_data_i | input | DATA_W | Byte from the device |
| dev_retry_o | output | 1 | Byte refused; the device must hold it and retry |
| host_rd_i | input | 1 | Host read strobe |
| host_addr_i | input | ADDR_W | Host read address |
| host_rdata_o | output | DATA_W | Read data (held byte on a data read, else 0) |
| full_o | output | 1 | Register holds an unread byte |
| irq_level_o | output | 1 | Interrupt request level |
| irq_pulse_o | output | 1 | One-cycle pulse on each new fill |

## Verification
Two events can fall in the same cycle: the host read that drains the register and the device's offer of its next byte. The bench provokes this by raising the read strobe and the device valid on the same falling edge while a byte is held. It checks that the read returns the old byte, that retry is high in that cycle, that nothing is captured on that edge, and that the still-offered byte is captured exactly one cycle later with a single fresh pulse.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;
  localparam int DATA_W_DEF = 8;
  localparam int ADDR_W_DEF = 8;

  // Address decode for the data port.
  function automatic logic addr_is(input logic [15:0] addr, input logic [15:0] target);
    return addr == target;
  endfunction

  // Next full state: a capture wins, else a clearing read drops it.
  function automatic logic next_full(input logic cur, input logic cap, input logic clr);
    if (cap) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction
endpackage

// File: rtl/kbd_flow_ctl.sv
module kbd_flow_ctl #(
  parameter int ADDR_W    = 8,
  parameter int DATA_ADDR = 'h60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_valid,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              full_q,
  output logic              accept,
  output logic              rd_hit,
  output logic              rd_clear,
  output logic              dev_retry
);
  import kbd_rx_pkg::*;
  localparam logic [15:0] TGT = 16'(DATA_ADDR);

  assign rd_hit    = host_rd && addr_is(16'(host_addr), TGT);
  assign rd_clear  = rd_hit && full_q;
  assign accept    = dev_valid && !full_q;
  assign dev_retry = dev_valid && full_q;

  AST_RETRY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_valid && full_q) |-> (dev_retry && !accept)); // R7
  AST_NO_CAPTURE_AND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && rd_clear)); // R8
endmodule

// File: rtl/kbd_hold_reg.sv
module kbd_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              rd_clear,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] hold_q,
  output logic              full_q
);
  import kbd_rx_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      hold_q <= '0;
    end else begin
      full_q <= next_full(full_q, accept, rd_clear);
      if (accept) hold_q <= din;
    end
  end

  AST_FILL_CAPTURES: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (full_q && hold_q == $past(din))); // R2
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !rd_clear) |=> (full_q && $stable(hold_q))); // R7
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clear |=> !full_q); // R5
endmodule

// File: rtl/kbd_irq_gen.sv
module kbd_irq_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic full_q,
  output logic irq_level,
  output logic irq_pulse
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= full_q;
  end

  assign irq_level = full_q;
  assign irq_pulse = full_q && !prev_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse); // R4
  AST_PULSE_ON_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> irq_level); // R3
endmodule

// File: rtl/kbd_rx_hold.sv
module kbd_rx_hold #(
  parameter int DATA_W    = kbd_rx_pkg::DATA_W_DEF,
  parameter int ADDR_W    = kbd_rx_pkg::ADDR_W_DEF,
  parameter int DATA_ADDR = 'h60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_valid_i,
  input  logic [DATA_W-1:0] dev_data_i,
  output logic              dev_retry_o,
  input  logic              host_rd_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              full_o,
  output logic              irq_level_o,
  output logic              irq_pulse_o
);
  logic              accept_w;
  logic              rd_hit_w;
  logic              rd_clear_w;
  logic              full_w;
  logic [DATA_W-1:0] hold_w;

  kbd_flow_ctl #(.ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR)) u_flow (
    .clk(clk), .rst_n(rst_n), .dev_valid(dev_valid_i), .host_rd(host_rd_i),
    .host_addr(host_addr_i), .full_q(full_w), .accept(accept_w),
    .rd_hit(rd_hit_w), .rd_clear(rd_clear_w), .dev_retry(dev_retry_o)
  );

  kbd_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .accept(accept_w), .rd_clear(rd_clear_w),
    .din(dev_data_i), .hold_q(hold_w), .full_q(full_w)
  );

  kbd_irq_gen u_irq (
    .clk(clk), .rst_n(rst_n), .full_q(full_w),
    .irq_level(irq_level_o), .irq_pulse(irq_pulse_o)
  );

  assign full_o       = full_w;
  assign host_rdata_o = rd_hit_w ? hold_w : '0;

  AST_EMPTY_READ_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit_w && !full_w && !dev_valid_i) |=> !irq_level_o); // R10
  AST_MISS_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_i && !rd_hit_w && full_w) |=> full_w); // R6
endmodule

// File: tb/kbd_rx_hold_test.sv
module kbd_rx_hold_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dev_valid = 1'b0;
  logic [7:0] dev_data = '0;
  logic       dev_retry;
  logic       host_rd = 1'b0;
  logic [7:0] host_addr = '0;
  logic [7:0] host_rdata;
  logic       full;
  logic       irq_level;
  logic       irq_pulse;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  kbd_rx_hold uut (
    .clk(clk), .rst_n(rst_n), .dev_valid_i(dev_valid), .dev_data_i(dev_data),
    .dev_retry_o(dev_retry), .host_rd_i(host_rd), .host_addr_i(host_addr),
    .host_rdata_o(host_rdata), .full_o(full), .irq_level_o(irq_level),
    .irq_pulse_o(irq_pulse)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Advance to the next falling edge, then settle.
  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic fill(input logic [7:0] b);
    dev_valid = 1'b1; dev_data = b; #1;
    chk("R2 no retry when empty", 8'(dev_retry), 8'd0);
    step();
    dev_valid = 1'b0;
    chk("R2 full after capture", 8'(full), 8'd1);
    chk("R4 pulse after fill", 8'(irq_pulse), 8'd1);
    chk("R3 level while full", 8'(irq_level), 8'd1);
    step();
    chk("R4 pulse one cycle", 8'(irq_pulse), 8'd0);
  endtask

  task automatic drain(input logic [7:0] b);
    host_rd = 1'b1; host_addr = 8'h60; #1;
    chk("R5 read data", host_rdata, b);
    step();
    host_rd = 1'b0;
    chk("R5 empty after read", 8'(full), 8'd0);
    chk("R3 level drops", 8'(irq_level), 8'd0);
    chk("R9 status cleared", 8'(full), 8'd0);
  endtask

  task automatic t_reset();
    chk("R1 full", 8'(full), 8'd0);
    chk("R1 irq", 8'(irq_level), 8'd0);
    chk("R1 pulse", 8'(irq_pulse), 8'd0);
    chk("R1 retry", 8'(dev_retry), 8'd0);
  endtask

  task automatic t_basic();
    fill(8'hA5);
    chk("R9 status full", 8'(full), 8'd1);
    drain(8'hA5);
    fill(8'h1C);
    drain(8'h1C);
  endtask

  task automatic t_wrong_addr();
    fill(8'h3E);
    host_rd = 1'b1; host_addr = 8'h64; #1;
    chk("R6 rdata zero", host_rdata, 8'h00);
    step();
    host_rd = 1'b0;
    chk("R6 still full", 8'(full), 8'd1);
    drain(8'h3E);
  endtask

  task automatic t_backpressure();
    fill(8'h55);
    dev_valid = 1'b1; dev_data = 8'hEE; #1;
    chk("R7 retry while full", 8'(dev_retry), 8'd1);
    step(); step();
    chk("R7 retry held", 8'(dev_retry), 8'd1);
    chk("R7 no new pulse", 8'(irq_pulse), 8'd0);
    dev_valid = 1'b0; #1;
    chk("R7 retry follows valid", 8'(dev_retry), 8'd0);
    drain(8'h55);
  endtask

  task automatic t_collision();
    fill(8'h77);
    dev_valid = 1'b1; dev_data = 8'h99;
    host_rd = 1'b1; host_addr = 8'h60; #1;
    chk("R8 read returns old byte", host_rdata, 8'h77);
    chk("R8 retry in same cycle", 8'(dev_retry), 8'd1);
    step();
    host_rd = 1'b0; #1;
    chk("R8 empty after read", 8'(full), 8'd0);
    chk("R8 retry released", 8'(dev_retry), 8'd0);
    step();
    dev_valid = 1'b0;
    chk("R8 captured next cycle", 8'(full), 8'd1);
    chk("R8 fresh pulse", 8'(irq_pulse), 8'd1);
    drain(8'h99);
  endtask

  task automatic t_empty_read();
    host_rd = 1'b1; host_addr = 8'h60;
    step();
    host_rd = 1'b0;
    chk("R10 stays empty", 8'(full), 8'd0);
    chk("R10 no irq", 8'(irq_level), 8'd0);
    step();
    chk("R10 no pulse", 8'(irq_pulse), 8'd0);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_basic();
    t_wrong_addr();
    t_backpressure();
    t_collision();
    t_empty_read();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule